// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block receives configuration words for a dual-loop frequency synthesizer over three wires: a serial data line, a shift strobe and a load strobe. All three wires are sampled in the core clock domain. Each rising transition of the shift strobe moves one data bit into a 23-bit shift register. A rising transition of the load strobe then copies the received word into one of four holding latches. The reference-divider latch and the main-divider latch exist once for the low-band loop and once for the high-band loop.

The first two bits of a word are a destination code. Reference words are 18 bits long and carry two test bits and a 14-bit reference ratio. Divider words are 23 bits long and carry a monitor-select flag, a prescaler-select flag, a phase-detector polarity flag, a 7-bit swallow count and an 11-bit main count. A saturating bit counter records how many bits arrived since the last load. This count decides how the register contents are framed.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset every latched output of both loops is zero.
- R2: One bit is captured per rising transition of `ser_clk`. For a 23-bit divider word, with position 1 sent first: positions 1–2 are the destination code (first bit D1, second D2), position 3 is the monitor-select flag, position 4 is the prescaler-select flag, position 5 is the polarity flag, positions 6–12 are the swallow count with its LSB at position 6, and positions 13–23 are the main count with its LSB at position 13.
- R3: The destination code selects the latch: D1=0,D2=0 low-band reference; D1=1,D2=0 high-band reference; D1=0,D2=1 low-band divider; D1=1,D2=1 high-band divider. At most one latch loads per event.
- R4: A load changes only the addressed latch. The other three keep their values.
- R5: In a reference word, position 3 drives test bit 1 and position 4 drives test bit 0. Positions 5–18 are the 14-bit ratio with its LSB at position 5. When 23 or more bits precede the load, the word is framed from the oldest of the last 23 bits, and positions 19–23 are ignored.
- R6: When 18 to 22 bits precede the load, the word is framed from the 18 most recent bits, and earlier bits are ignored.
- R7: A load with fewer than 18 bits since the previous load changes nothing. So does a short frame (18–22 bits) whose code names a divider latch.
- R8: Loading happens only on a rising transition of `ser_le`. Holding it high while more bits are shifted causes no reload. Those bits count toward the next load.
- R9: Shifting bits with `ser_le` low leaves all latched outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift strobe |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe |
| lo_ref_ratio | output | 14 | Low-band reference ratio |
| lo_test | output | 2 | Low-band test bits {T1,T0} |
| lo_main | output | 11 | Low-band main count |
| lo_swallow | output | 7 | Low-band swallow count |
| lo_presc_sel | output | 1 | Low-band prescaler select |
| lo_pd_invert | output | 1 | Low-band polarity flag |
| lo_mon_sel | output | 1 | Low-band monitor select |
| hi_ref_ratio | output | 14 | High-band reference ratio |
| hi_test | output | 2 | High-band test bits {T1,T0} |
| hi_main | output | 11 | High-band main count |
| hi_swallow | output | 7 | High-band swallow count |
| hi_presc_sel | output | 1 | High-band prescaler select |
| hi_pd_invert | output | 1 | High-band polarity flag |
| hi_mon_sel | output | 1 | High-band monitor select |

## Verification
The assertions assume each level of the three serial wires lasts longer than the synchronizer depth plus one core cycle. Under that condition every transition shows up as a single one-cycle pulse. They also assume that data is stable around each shift strobe edge. The stimulus holds every serial phase for four core cycles and changes data only while the shift strobe is low. Shift and load activity are never moved in the same phase. The random words mix all four destinations, both frame lengths and random field contents. Directed cases cover short, overlong and truncated frames and a held load strobe.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  localparam int REF_W   = 14;
  localparam int MAIN_W  = 11;
  localparam int SWAL_W  = 7;
  localparam int TEST_W  = 2;
  localparam int CODE_W  = 2;
  localparam int REF_FRAME = CODE_W + TEST_W + REF_W;          // 18
  localparam int DIV_FRAME = CODE_W + 3 + SWAL_W + MAIN_W;     // 23
  localparam int NUM_LOOPS = 2;

  typedef struct packed {
    logic [TEST_W-1:0] test;
    logic [REF_W-1:0]  ratio;
  } ref_word_t;

  typedef struct packed {
    logic              mon_sel;
    logic              presc_sel;
    logic              pd_invert;
    logic [SWAL_W-1:0] swallow;
    logic [MAIN_W-1:0] main;
  } div_word_t;
endpackage

// File: rtl/ssl_input_sync.sv
module ssl_input_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] rise
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q, stage_nx;
  logic [WIDTH-1:0]             prev_q;

  always_comb begin
    stage_nx[0] = din;
    for (int s = 1; s < STAGES; s++) stage_nx[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= stage_nx;
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign dout = stage_q[STAGES-1];
  assign rise = dout & ~prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chk
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]) else $error("edge pulse lasted two cycles"); // R8
  end
endmodule

// File: rtl/ssl_frame.sv
module ssl_frame
  import ssl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 bit_in,
  input  logic                 load_en,
  output logic [NUM_LOOPS-1:0] ld_ref,
  output logic [NUM_LOOPS-1:0] ld_div,
  output ref_word_t            ref_w,
  output div_word_t            div_w
);
  localparam int CNT_W = $clog2(DIV_FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV_FRAME);
  localparam logic [CNT_W-1:0] CNT_REF = CNT_W'(REF_FRAME);

  logic [DIV_FRAME-1:0] sr_q, sr_nx;
  logic [CNT_W-1:0]     cnt_q, cnt_nx;
  logic                 is_long, is_short, cn1, cn2;
  ref_word_t            ref_long, ref_short;

  // next state
  always_comb begin
    sr_nx  = sr_q;
    cnt_nx = cnt_q;
    if (shift_en) sr_nx = {sr_q[DIV_FRAME-2:0], bit_in};
    if (load_en)                            cnt_nx = '0;
    else if (shift_en && cnt_q != CNT_MAX)  cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_nx;
      cnt_q <= cnt_nx;
    end
  end

  // framing: position p of an L-bit frame sits at sr_q[L-p]
  always_comb begin
    ref_long.test  = {sr_q[DIV_FRAME-3], sr_q[DIV_FRAME-4]};
    ref_short.test = {sr_q[REF_FRAME-3], sr_q[REF_FRAME-4]};
    for (int i = 0; i < REF_W; i++) begin
      ref_long.ratio[i]  = sr_q[DIV_FRAME-5-i];
      ref_short.ratio[i] = sr_q[REF_FRAME-5-i];
    end
    div_w.mon_sel   = sr_q[DIV_FRAME-3];
    div_w.presc_sel = sr_q[DIV_FRAME-4];
    div_w.pd_invert = sr_q[DIV_FRAME-5];
    for (int i = 0; i < SWAL_W; i++) div_w.swallow[i] = sr_q[DIV_FRAME-6-i];
    for (int i = 0; i < MAIN_W; i++) div_w.main[i]    = sr_q[MAIN_W-1-i];
  end

  assign is_long  = (cnt_q == CNT_MAX);
  assign is_short = (cnt_q >= CNT_REF) && !is_long;
  assign cn1      = is_long ? sr_q[DIV_FRAME-1] : sr_q[REF_FRAME-1];
  assign cn2      = is_long ? sr_q[DIV_FRAME-2] : sr_q[REF_FRAME-2];
  assign ref_w    = is_long ? ref_long : ref_short;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_dec
    assign ld_ref[g] = load_en && (is_long || is_short) && !cn2 && (cn1 == g[0]);
    assign ld_div[g] = load_en && is_long && cn2 && (cn1 == g[0]);
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_ref, ld_div})) else $error("two latches addressed"); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX) else $error("bit count overran"); // R7
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == '0) else $error("count not cleared by load"); // R8
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(bit_in)) else $error("bit not captured"); // R2
endmodule

// File: rtl/ssl_loop_latch.sv
module ssl_loop_latch
  import ssl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_ref,
  input  logic      ld_div,
  input  ref_word_t ref_w,
  input  div_word_t div_w,
  output ref_word_t ref_q,
  output div_word_t div_q
);
  ref_word_t ref_nx;
  div_word_t div_nx;

  always_comb begin
    ref_nx = ld_ref ? ref_w : ref_q;
    div_nx = ld_div ? div_w : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      div_q <= '0;
    end else begin
      ref_q <= ref_nx;
      div_q <= div_nx;
    end
  end

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ref |=> $stable(ref_q)) else $error("reference latch moved"); // R4
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_div |=> $stable(div_q)) else $error("divider latch moved"); // R4
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import ssl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [REF_W-1:0]  lo_ref_ratio,
  output logic [TEST_W-1:0] lo_test,
  output logic [MAIN_W-1:0] lo_main,
  output logic [SWAL_W-1:0] lo_swallow,
  output logic              lo_presc_sel,
  output logic              lo_pd_invert,
  output logic              lo_mon_sel,
  output logic [REF_W-1:0]  hi_ref_ratio,
  output logic [TEST_W-1:0] hi_test,
  output logic [MAIN_W-1:0] hi_main,
  output logic [SWAL_W-1:0] hi_swallow,
  output logic              hi_presc_sel,
  output logic              hi_pd_invert,
  output logic              hi_mon_sel
);
  logic [2:0]           s_lvl, s_rise;
  logic [NUM_LOOPS-1:0] ld_ref, ld_div;
  ref_word_t            ref_w;
  div_word_t            div_w;
  ref_word_t            ref_q [NUM_LOOPS];
  div_word_t            div_q [NUM_LOOPS];

  ssl_input_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ser_le, ser_data, ser_clk}),
    .dout(s_lvl), .rise(s_rise));

  ssl_frame u_frame (
    .clk(clk), .rst_n(rst_n), .shift_en(s_rise[0]), .bit_in(s_lvl[1]),
    .load_en(s_rise[2]), .ld_ref(ld_ref), .ld_div(ld_div),
    .ref_w(ref_w), .div_w(div_w));

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    ssl_loop_latch u_latch (
      .clk(clk), .rst_n(rst_n), .ld_ref(ld_ref[g]), .ld_div(ld_div[g]),
      .ref_w(ref_w), .div_w(div_w), .ref_q(ref_q[g]), .div_q(div_q[g]));
  end

  assign {lo_test, lo_ref_ratio} = ref_q[0];
  assign {hi_test, hi_ref_ratio} = ref_q[1];
  assign {lo_mon_sel, lo_presc_sel, lo_pd_invert, lo_swallow, lo_main} = div_q[0];
  assign {hi_mon_sel, hi_presc_sel, hi_pd_invert, hi_swallow, hi_main} = div_q[1];

  AST_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_rise[2] |=> $stable({lo_main, hi_main, lo_ref_ratio, hi_ref_ratio}))
    else $error("output changed without a load edge"); // R9
endmodule

// File: tb/synth_serial_loader_bench.sv
module synth_serial_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 4;

  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_le = 0;
  logic [13:0] lo_ref_ratio, hi_ref_ratio;
  logic [1:0]  lo_test, hi_test;
  logic [10:0] lo_main, hi_main;
  logic [6:0]  lo_swallow, hi_swallow;
  logic lo_presc_sel, lo_pd_invert, lo_mon_sel, hi_presc_sel, hi_pd_invert, hi_mon_sel;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [22:0] q_m = '0;
  int          n_m = 0;
  logic [15:0] e_ref [2];
  logic [20:0] e_div [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_serial_loader u_synth_serial_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .lo_ref_ratio(lo_ref_ratio), .lo_test(lo_test), .lo_main(lo_main),
    .lo_swallow(lo_swallow), .lo_presc_sel(lo_presc_sel), .lo_pd_invert(lo_pd_invert),
    .lo_mon_sel(lo_mon_sel), .hi_ref_ratio(hi_ref_ratio), .hi_test(hi_test),
    .hi_main(hi_main), .hi_swallow(hi_swallow), .hi_presc_sel(hi_presc_sel),
    .hi_pd_invert(hi_pd_invert), .hi_mon_sel(hi_mon_sel));

  function automatic logic [17:0] mk_ref(logic cn1, logic t1, logic t0, logic [13:0] r);
    logic [17:0] w;
    w[17] = cn1; w[16] = 1'b0; w[15] = t1; w[14] = t0;
    for (int i = 0; i < 14; i++) w[13-i] = r[i];
    return w;
  endfunction

  function automatic logic [22:0] mk_div(logic cn1, logic mon, logic psel, logic inv,
                                         logic [6:0] a, logic [10:0] n);
    logic [22:0] w;
    w[22] = cn1; w[21] = 1'b1; w[20] = mon; w[19] = psel; w[18] = inv;
    for (int i = 0; i < 7; i++)  w[17-i] = a[i];
    for (int i = 0; i < 11; i++) w[10-i] = n[i];
    return w;
  endfunction

  // expected effect of a load, from R2 R3 R5 R6 R7
  task automatic model_load();
    logic [15:0] rv;
    logic [20:0] dv;
    if (n_m >= 23) begin
      rv[15] = q_m[20]; rv[14] = q_m[19];
      for (int i = 0; i < 14; i++) rv[i] = q_m[18-i];
      dv[20] = q_m[20]; dv[19] = q_m[19]; dv[18] = q_m[18];
      for (int i = 0; i < 7; i++)  dv[11+i] = q_m[17-i];
      for (int i = 0; i < 11; i++) dv[i]    = q_m[10-i];
      if (q_m[21]) e_div[q_m[22]] = dv;
      else         e_ref[q_m[22]] = rv;
    end else if (n_m >= 18 && !q_m[16]) begin
      rv[15] = q_m[15]; rv[14] = q_m[14];
      for (int i = 0; i < 14; i++) rv[i] = q_m[13-i];
      e_ref[q_m[17]] = rv;
    end
    n_m = 0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); ser_data = b;
    idle(PHASE); ser_clk = 1;
    idle(PHASE); ser_clk = 0;
    q_m = {q_m[21:0], b};
    if (n_m < 23) n_m++;
  endtask

  task automatic send_word(logic [22:0] w, int len);
    for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic le_pulse();
    @(negedge clk); ser_le = 1; model_load();
    idle(2*PHASE); ser_le = 0; idle(2*PHASE);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " lo-ref"}, 32'({lo_test, lo_ref_ratio}), 32'(e_ref[0]));
    chk({tag, " hi-ref"}, 32'({hi_test, hi_ref_ratio}), 32'(e_ref[1]));
    chk({tag, " lo-div"}, 32'({lo_mon_sel, lo_presc_sel, lo_pd_invert, lo_swallow, lo_main}),
        32'(e_div[0]));
    chk({tag, " hi-div"}, 32'({hi_mon_sel, hi_presc_sel, hi_pd_invert, hi_swallow, hi_main}),
        32'(e_div[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    e_ref[0] = '0; e_ref[1] = '0; e_div[0] = '0; e_div[1] = '0;
    idle(5); rst_n = 1; idle(5);
    check_all("R1 reset");

    send_word(23'(mk_ref(1'b0, 1'b1, 1'b0, 14'h1A5C)), 18); le_pulse();
    check_all("R3 R5 lo ref");
    send_word(23'(mk_ref(1'b1, 1'b0, 1'b1, 14'h3FFF)), 18); le_pulse();
    check_all("R3 R5 hi ref");
    send_word(mk_div(1'b0, 1'b1, 1'b0, 1'b1, 7'h55, 11'h403), 23); le_pulse();
    check_all("R2 R3 lo div");
    send_word(mk_div(1'b1, 1'b0, 1'b1, 1'b0, 7'h7F, 11'h7FF), 23); le_pulse();
    check_all("R2 R3 hi div");

    send_word({mk_ref(1'b1, 1'b1, 1'b1, 14'h0005), 5'b10110}, 23); le_pulse();
    check_all("R5 long frame tail ignored");
    send_word(23'({2'b11, mk_ref(1'b0, 1'b0, 1'b0, 14'h2222)}), 20); le_pulse();
    check_all("R6 short frame leading bits ignored");

    send_word(23'h2AB, 10); le_pulse();
    check_all("R7 too few bits");
    send_word(23'({2'b11, 16'hBEEF}), 18); le_pulse();
    check_all("R7 short divider code");

    send_word(mk_div(1'b0, 1'b0, 1'b0, 1'b0, 7'h01, 11'h005), 23); idle(4*PHASE);
    check_all("R9 shift without load");

    @(negedge clk); ser_le = 1; model_load(); idle(2*PHASE);
    check_all("R8 first edge loads");
    send_word(mk_div(1'b1, 1'b1, 1'b1, 1'b1, 7'h12, 11'h345), 23); idle(4*PHASE);
    check_all("R8 held high no reload");
    ser_le = 0; idle(2*PHASE); le_pulse();
    check_all("R8 next edge loads");

    for (int it = 0; it < 40; it++) begin
      int kind;
      logic c1;
      kind = int'($urandom % 4);
      c1 = kind[0];
      if (kind >= 2)
        send_word(mk_div(c1, 1'($urandom), 1'($urandom), 1'($urandom),
                         7'($urandom), 11'($urandom)), 23);
      else if ($urandom % 2 == 0)
        send_word(23'(mk_ref(c1, 1'($urandom), 1'($urandom), 14'($urandom))), 18);
      else
        send_word({mk_ref(c1, 1'($urandom), 1'($urandom), 14'($urandom)), 5'($urandom)}, 23);
      le_pulse();
      check_all("R4 random word");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule